// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block paces one successive-approximation conversion cycle, counting in periods of its own clock. Each cycle passes through three phases in fixed order: sampling, bit-by-bit comparison, and a final transfer phase that places the digital value in a result register. The duration of each phase comes from a lookup on two 2-bit codes: a conversion-speed code and a sample-time code. Both codes are latched at the moment a cycle is launched.

A cycle is launched either as a standard conversion or as an injected conversion. A standard result lands in the main result register. An injected result lands only in a second result register. An inject request that arrives while a cycle is running is held and runs right after that cycle. The comparator value is an input, supplied by an external model.

Two 8-bit interrupt control registers record events. The first flags the end of every conversion. The second flags two things: a standard result that replaces a value nobody has read, and the storing of an injected result.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset all three phase outputs and `injected_o` are 0, both result registers are 0 and both control registers are 0x00.
- R2: A launched cycle shows `sample_o`, then `compare_o`, then `transfer_o`, each for a fixed number of clock cycles, with exactly one of them high while busy. The cycle counts (sample+compare+transfer) depend on the conversion code and the sample code, with sample codes 0..3 taken in order:
  - Conversion code 00: 120+240+28, 140+280+16, 200+280+52, 400+280+44.
  - Conversion code 10: 480+960+100, 560+1120+52, 800+1120+196, 1600+1120+164.
  - Conversion code 11: 240+480+52, 280+560+28, 400+560+100, 800+560+52.
- R3: Conversion code 01 is reserved and gives exactly the timing of conversion code 00 for the same sample code.
- R4: Both codes are latched when a cycle is launched. Changing them while the cycle runs leaves that cycle's phase lengths unchanged.
- R5: `start_i` is honoured only while idle. A start pulse during a running cycle neither restarts it nor queues a second cycle.
- R6: The comparator value present during the last comparison cycle is the one stored. It appears on `result_o` after the last transfer cycle of a standard conversion, even if the input changes during the transfer phase. At that same point bit 7 of `eoc_ctl_o` is set; this happens at the end of every conversion.
- R7: A standard result sets bit 7 of `err_ctl_o` when the previous standard result was never read. A one-cycle `rd_strobe_i` marks the current result as read, so the next standard result does not set that bit.
- R8: An `inject_i` pulse during a standard conversion is held. Its sampling phase starts in the cycle right after the standard conversion ends, with `injected_o` high. Its result goes only to `inj_result_o`, and storing it sets bit 7 of `err_ctl_o`.
- R9: When `start_i` and `inject_i` arrive together while idle, the injected conversion runs and the standard start is dropped.
- R10: A write (`icr_wr_i[0]` for the end-of-conversion register, `icr_wr_i[1]` for the error/injection register) loads `icr_wdata_i` whole. The fields are request bit 7, enable bit 6, level bits 5:2 and group bits 1:0. A hardware set of bit 7 in the same cycle wins over the written bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock; one period is the timing unit |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Standard conversion request (honoured when idle) |
| inject_i | input | 1 | Injected conversion request (held if busy) |
| conv_code_i | input | 2 | Conversion-speed code (01 reserved) |
| samp_code_i | input | 2 | Sample-time code |
| cmp_result_i | input | RES_W | Value from the external comparator model |
| rd_strobe_i | input | 1 | Read of the standard result register |
| icr_wr_i | input | 2 | Write enables: bit 0 end-of-conversion register, bit 1 error/injection register |
| icr_wdata_i | input | 8 | Write data for the control registers |
| sample_o | output | 1 | Sampling phase active |
| compare_o | output | 1 | Comparison phase active |
| transfer_o | output | 1 | Transfer phase active |
| injected_o | output | 1 | The running cycle is an injected conversion |
| result_o | output | RES_W | Standard result register |
| inj_result_o | output | RES_W | Injected result register |
| eoc_ctl_o | output | 8 | End-of-conversion interrupt control register |
| err_ctl_o | output | 8 | Error/injection interrupt control register |

## Verification
Every pairing of the two codes is run, and the length of each phase is counted at the ports. The three phase lengths separate the lookup entries from each other, so a swapped or shifted entry shows up. The reserved code is run against the matching code-00 lengths. A further cycle flips the codes just after launch, which shows whether they are latched or re-read. Result tests vary the comparator input during the transfer phase, interleave reads with unread writes, and overlap inject with start both mid-cycle and at the same instant. Together these separate the overrun cause of the shared flag from the injection cause.

// File: rtl/adc_seq_pkg.sv
// Package adc_seq_pkg
// Shared types, constants and the phase-length lookup of the conversion
// timing sequencer. Assumes that lengths never exceed 2**CNT_W - 1 cycles.
package adc_seq_pkg;

    localparam int CNT_W   = 11;   // wide enough for the longest phase (1600)
    localparam int CTL_W   = 8;    // interrupt control register width
    localparam int REQ_BIT = 7;    // request flag position
    localparam int NUM_ICR = 2;    // end-of-conversion, error/injection

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_COMPARE,
        PH_EXTRA
    } phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] smp;
        logic [CNT_W-1:0] cmp;
        logic [CNT_W-1:0] ext;
    } ph_len_t;

    // Phase lengths for a (conversion code, sample code) pair.
    // Sample and comparison scale by 1, 2 or 4 with the conversion code;
    // the transfer length follows no rule and is listed per entry.
    function automatic ph_len_t lookup_len(input logic [1:0] conv,
                                           input logic [1:0] smp);
        ph_len_t r;
        int      scale;
        int      s_base;
        int      c_base;
        int      ext;
        unique case (conv)
            2'b11:   scale = 2;
            2'b10:   scale = 4;
            default: scale = 1;   // 00 and reserved 01
        endcase
        unique case (smp)
            2'b00:   s_base = 120;
            2'b01:   s_base = 140;
            2'b10:   s_base = 200;
            default: s_base = 400;
        endcase
        c_base = (smp == 2'b00) ? 240 : 280;
        unique case ({scale[2:0], smp})
            {3'd2, 2'b00}: ext = 52;
            {3'd2, 2'b01}: ext = 28;
            {3'd2, 2'b10}: ext = 100;
            {3'd2, 2'b11}: ext = 52;
            {3'd4, 2'b00}: ext = 100;
            {3'd4, 2'b01}: ext = 52;
            {3'd4, 2'b10}: ext = 196;
            {3'd4, 2'b11}: ext = 164;
            {3'd1, 2'b00}: ext = 28;
            {3'd1, 2'b01}: ext = 16;
            {3'd1, 2'b10}: ext = 52;
            default:       ext = 44;
        endcase
        r.smp = CNT_W'(s_base * scale);
        r.cmp = CNT_W'(c_base * scale);
        r.ext = CNT_W'(ext);
        return r;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
// Module adc_seq_timer
// Phase state machine and down-counter. Launches a cycle from idle or
// straight after the last transfer cycle, gives a held inject request
// priority, and latches the phase lengths at launch.
// Assumes start_i/inject_i are synchronous to clk.
module adc_seq_timer
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       inject_i,
    input  logic [1:0] conv_code_i,
    input  logic [1:0] samp_code_i,
    output phase_e     phase_o,
    output logic       inj_o,
    output logic       cap_o,
    output logic       done_o,
    output logic       done_inj_o
);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_len_q;
    logic [CNT_W-1:0] ext_len_q;
    logic             cur_inj_q;
    logic             inj_pend_q;

    ph_len_t          len_sel;
    logic             last_cyc;
    logic             done;
    logic             can_launch;
    logic             want_inj;
    logic             launch_inj;
    logic             launch_std;

    // Launch decision and end-of-phase detection.
    always_comb begin
        len_sel    = lookup_len(conv_code_i, samp_code_i);
        last_cyc   = (cnt_q == '0);
        done       = (ph_q == PH_EXTRA) && last_cyc;
        can_launch = (ph_q == PH_IDLE) || done;
        want_inj   = inj_pend_q || inject_i;
        launch_inj = can_launch && want_inj;
        launch_std = (ph_q == PH_IDLE) && start_i && !want_inj;
    end

    // Phase sequencing and cycle counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            cnt_q     <= '0;
            cmp_len_q <= '0;
            ext_len_q <= '0;
            cur_inj_q <= 1'b0;
        end else if (launch_inj || launch_std) begin
            ph_q      <= PH_SAMPLE;
            cnt_q     <= len_sel.smp - CNT_W'(1);
            cmp_len_q <= len_sel.cmp;
            ext_len_q <= len_sel.ext;
            cur_inj_q <= launch_inj;
        end else begin
            unique case (ph_q)
                PH_SAMPLE: begin
                    if (last_cyc) begin
                        ph_q  <= PH_COMPARE;
                        cnt_q <= cmp_len_q - CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_COMPARE: begin
                    if (last_cyc) begin
                        ph_q  <= PH_EXTRA;
                        cnt_q <= ext_len_q - CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_EXTRA: begin
                    if (last_cyc) begin
                        ph_q      <= PH_IDLE;
                        cur_inj_q <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Hold an inject request until it can be launched.
    always_ff @(posedge clk) begin
        if (!rst_n)          inj_pend_q <= 1'b0;
        else if (launch_inj) inj_pend_q <= 1'b0;
        else if (inject_i)   inj_pend_q <= 1'b1;
    end

    assign phase_o    = ph_q;
    assign inj_o      = cur_inj_q;
    assign cap_o      = (ph_q == PH_COMPARE) && last_cyc;
    assign done_o     = done;
    assign done_inj_o = done && cur_inj_q;

endmodule

// File: rtl/adc_seq_result.sv
// Module adc_seq_result
// Result path: holds the comparator value taken in the last comparison
// cycle, writes it to the standard or injected register at the end of the
// transfer phase, and tracks whether the standard result has been read.
// Assumes cap_i and done_i are single-cycle pulses from the timer.
module adc_seq_result #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic             done_i,
    input  logic             done_inj_i,
    input  logic [RES_W-1:0] cmp_i,
    input  logic             rd_i,
    output logic [RES_W-1:0] std_res_o,
    output logic [RES_W-1:0] inj_res_o,
    output logic             overrun_o
);

    logic [RES_W-1:0] hold_q;
    logic             unread_q;
    logic             std_store;

    assign std_store = done_i && !done_inj_i;

    // Capture and store of conversion values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            std_res_o <= '0;
            inj_res_o <= '0;
        end else begin
            if (cap_i)      hold_q    <= cmp_i;
            if (std_store)  std_res_o <= hold_q;
            if (done_inj_i) inj_res_o <= hold_q;
        end
    end

    // Unread tracking of the standard result; a new store wins over a read.
    always_ff @(posedge clk) begin
        if (!rst_n)         unread_q <= 1'b0;
        else if (std_store) unread_q <= 1'b1;
        else if (rd_i)      unread_q <= 1'b0;
    end

    assign overrun_o = std_store && unread_q && !rd_i;

endmodule

// File: rtl/adc_seq_icr.sv
// Module adc_seq_icr
// One interrupt control register: software loads the whole byte, hardware
// sets the request bit. Assumes the hardware set has priority on bit REQ_BIT.
module adc_seq_icr
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CTL_W-1:0] wdata_i,
    input  logic             set_i,
    output logic [CTL_W-1:0] ctl_o
);

    // Register update with request-set priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_o <= '0;
        end else begin
            if (wr_i)  ctl_o          <= wdata_i;
            if (set_i) ctl_o[REQ_BIT] <= 1'b1;
        end
    end

endmodule

// File: rtl/adc_conv_seq.sv
// Module adc_conv_seq
// Top of the conversion timing sequencer: timer, result path and the two
// interrupt control registers (index 0 end-of-conversion, index 1
// error/injection). Assumes all inputs are synchronous to clk.
module adc_conv_seq
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               inject_i,
    input  logic [1:0]         conv_code_i,
    input  logic [1:0]         samp_code_i,
    input  logic [RES_W-1:0]   cmp_result_i,
    input  logic               rd_strobe_i,
    input  logic [NUM_ICR-1:0] icr_wr_i,
    input  logic [CTL_W-1:0]   icr_wdata_i,
    output logic               sample_o,
    output logic               compare_o,
    output logic               transfer_o,
    output logic               injected_o,
    output logic [RES_W-1:0]   result_o,
    output logic [RES_W-1:0]   inj_result_o,
    output logic [CTL_W-1:0]   eoc_ctl_o,
    output logic [CTL_W-1:0]   err_ctl_o
);

    phase_e             phase;
    logic               inj_run;
    logic               cap;
    logic               done;
    logic               done_inj;
    logic               overrun;
    logic [NUM_ICR-1:0] set_req;
    logic [CTL_W-1:0]   ctl_w [NUM_ICR];

    adc_seq_timer u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .inject_i    (inject_i),
        .conv_code_i (conv_code_i),
        .samp_code_i (samp_code_i),
        .phase_o     (phase),
        .inj_o       (inj_run),
        .cap_o       (cap),
        .done_o      (done),
        .done_inj_o  (done_inj)
    );

    adc_seq_result #(.RES_W(RES_W)) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_i      (cap),
        .done_i     (done),
        .done_inj_i (done_inj),
        .cmp_i      (cmp_result_i),
        .rd_i       (rd_strobe_i),
        .std_res_o  (result_o),
        .inj_res_o  (inj_result_o),
        .overrun_o  (overrun)
    );

    // Request sources: every end of conversion; overrun or injected store.
    assign set_req = {overrun || done_inj, done};

    for (genvar i = 0; i < NUM_ICR; i++) begin : g_icr
        adc_seq_icr u_icr (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_i    (icr_wr_i[i]),
            .wdata_i (icr_wdata_i),
            .set_i   (set_req[i]),
            .ctl_o   (ctl_w[i])
        );
    end

    assign eoc_ctl_o  = ctl_w[0];
    assign err_ctl_o  = ctl_w[1];
    assign sample_o   = (phase == PH_SAMPLE);
    assign compare_o  = (phase == PH_COMPARE);
    assign transfer_o = (phase == PH_EXTRA);
    assign injected_o = inj_run;

endmodule

// File: rtl/adc_conv_seq_chk.sv
// Module adc_conv_seq_chk
// Port-level assertions for adc_conv_seq, attached with bind below.
module adc_conv_seq_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_o,
    input logic             compare_o,
    input logic             transfer_o,
    input logic             injected_o,
    input logic [RES_W-1:0] result_o,
    input logic [7:0]       eoc_ctl_o
);

    // R2: at most one phase indicator at a time
    a_r2_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_o, compare_o, transfer_o}));

    // R2: sampling is followed by comparison
    a_r2_sample_to_compare: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_o) |-> compare_o);

    // R2: comparison is followed by transfer
    a_r2_compare_to_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(compare_o) |-> transfer_o);

    // R6: end of a cycle leaves the end-of-conversion request set
    a_r6_eoc_set: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(transfer_o) |-> eoc_ctl_o[7]);

    // R8: an injected cycle leaves the standard result untouched
    a_r8_std_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(transfer_o) && $past(injected_o)) |-> $stable(result_o));

    // R8: injected marker only while a cycle runs
    a_r8_inj_busy: assert property (@(posedge clk) disable iff (!rst_n)
        injected_o |-> (sample_o || compare_o || transfer_o));

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_o   (sample_o),
    .compare_o  (compare_o),
    .transfer_o (transfer_o),
    .injected_o (injected_o),
    .result_o   (result_o),
    .eoc_ctl_o  (eoc_ctl_o)
);

// File: tb/adc_conv_seq_test.sv
// Directed bench for adc_conv_seq: one task per scenario.
module adc_conv_seq_test;

    localparam int RW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          inject_i = 1'b0;
    logic [1:0]    conv_code_i = 2'b00;
    logic [1:0]    samp_code_i = 2'b00;
    logic [RW-1:0] cmp_result_i = '0;
    logic          rd_strobe_i = 1'b0;
    logic [1:0]    icr_wr_i = 2'b00;
    logic [7:0]    icr_wdata_i = 8'h00;
    logic          sample_o, compare_o, transfer_o, injected_o;
    logic [RW-1:0] result_o, inj_result_o;
    logic [7:0]    eoc_ctl_o, err_ctl_o;

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;
    bit finished = 0;

    adc_conv_seq #(.RES_W(RW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .inject_i(inject_i),
        .conv_code_i(conv_code_i), .samp_code_i(samp_code_i),
        .cmp_result_i(cmp_result_i), .rd_strobe_i(rd_strobe_i),
        .icr_wr_i(icr_wr_i), .icr_wdata_i(icr_wdata_i),
        .sample_o(sample_o), .compare_o(compare_o), .transfer_o(transfer_o),
        .injected_o(injected_o), .result_o(result_o), .inj_result_o(inj_result_o),
        .eoc_ctl_o(eoc_ctl_o), .err_ctl_o(err_ctl_o)
    );

    always #5 clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // Expected lengths written from the requirement table (R2, R3).
    task automatic exp_len(input logic [1:0] cv, input logic [1:0] sp,
                           output int s, output int c, output int e);
        int k;
        k = (cv == 2'b01 || cv == 2'b00) ? 0 : (cv == 2'b10 ? 1 : 2);
        case (k * 4 + int'(sp))
            0:  begin s = 120;  c = 240;  e = 28;  end
            1:  begin s = 140;  c = 280;  e = 16;  end
            2:  begin s = 200;  c = 280;  e = 52;  end
            3:  begin s = 400;  c = 280;  e = 44;  end
            4:  begin s = 480;  c = 960;  e = 100; end
            5:  begin s = 560;  c = 1120; e = 52;  end
            6:  begin s = 800;  c = 1120; e = 196; end
            7:  begin s = 1600; c = 1120; e = 164; end
            8:  begin s = 240;  c = 480;  e = 52;  end
            9:  begin s = 280;  c = 560;  e = 28;  end
            10: begin s = 400;  c = 560;  e = 100; end
            default: begin s = 800; c = 560; e = 52; end
        endcase
    endtask

    task automatic wr_ctl(input int idx, input logic [7:0] val);
        @(negedge clk);
        icr_wr_i[idx] = 1'b1;
        icr_wdata_i   = val;
        @(negedge clk);
        icr_wr_i = 2'b00;
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        rd_strobe_i = 1'b1;
        @(negedge clk);
        rd_strobe_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (sample_o || compare_o || transfer_o) @(negedge clk);
    endtask

    // Run one standard conversion; mode 1 flips codes after launch,
    // mode 2 pulses start mid-cycle. Changes the comparator value in transfer.
    task automatic run_conv(input logic [1:0] cv, input logic [1:0] sp,
                            input logic [RW-1:0] val, input int mode,
                            output int s, output int c, output int e);
        s = 0; c = 0; e = 0;
        @(negedge clk);
        conv_code_i  = cv;
        samp_code_i  = sp;
        cmp_result_i = val;
        start_i      = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mode == 1) begin
            conv_code_i = 2'b10;
            samp_code_i = 2'b11;
        end
        while (sample_o || compare_o || transfer_o) begin
            if (sample_o)   s++;
            if (compare_o)  c++;
            if (transfer_o) begin
                e++;
                cmp_result_i = ~val;
            end
            start_i = (mode == 2 && c == 10) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    task automatic t_reset();
        check(!sample_o && !compare_o && !transfer_o && !injected_o, "R1 phases idle",
              int'({sample_o, compare_o, transfer_o, injected_o}), 0);
        check(result_o == 0 && inj_result_o == 0, "R1 results zero", int'(result_o), 0);
        check(eoc_ctl_o == 0 && err_ctl_o == 0, "R1 control registers zero",
              int'({eoc_ctl_o, err_ctl_o}), 0);
    endtask

    task automatic t_timing();
        for (int cv = 0; cv < 4; cv++) begin
            for (int sp = 0; sp < 4; sp++) begin
                int s, c, e, xs, xc, xe;
                exp_len(2'(cv), 2'(sp), xs, xc, xe);
                run_conv(2'(cv), 2'(sp), RW'(cv * 16 + sp + 1), 0, s, c, e);
                if (cv == 1) begin
                    check(s == xs && c == xc && e == xe, "R3 reserved code timing", s + c + e, xs + xc + xe);
                end else begin
                    check(s == xs, "R2 sample length", s, xs);
                    check(c == xc, "R2 compare length", c, xc);
                    check(e == xe, "R2 transfer length", e, xe);
                end
            end
        end
    endtask

    task automatic t_latch_codes();
        int s, c, e;
        run_conv(2'b00, 2'b00, 10'h055, 1, s, c, e);
        check(s == 120 && c == 240 && e == 28, "R4 codes latched at launch", s + c + e, 388);
    endtask

    task automatic t_busy_start();
        int s, c, e;
        run_conv(2'b00, 2'b01, 10'h066, 2, s, c, e);
        check(s == 140 && c == 280 && e == 16, "R5 start ignored while busy", s + c + e, 436);
        repeat (3) @(negedge clk);
        check(!sample_o && !compare_o, "R5 no queued cycle", int'(sample_o), 0);
    endtask

    task automatic t_result_overrun();
        int s, c, e;
        wr_ctl(0, 8'h00);
        wr_ctl(1, 8'h00);
        rd_pulse();
        run_conv(2'b00, 2'b00, 10'h2A5, 0, s, c, e);
        check(result_o == 10'h2A5, "R6 stored value from comparison", int'(result_o), 'h2A5);
        check(eoc_ctl_o == 8'h80, "R6 end-of-conversion request", int'(eoc_ctl_o), 'h80);
        check(err_ctl_o == 8'h00, "R7 read result gives no overrun", int'(err_ctl_o), 0);
        run_conv(2'b00, 2'b00, 10'h13C, 0, s, c, e);
        check(err_ctl_o == 8'h80, "R7 unread result overrun", int'(err_ctl_o), 'h80);
        check(result_o == 10'h13C, "R6 second result", int'(result_o), 'h13C);
        wr_ctl(1, 8'h00);
        rd_pulse();
        run_conv(2'b00, 2'b00, 10'h0F0, 0, s, c, e);
        check(err_ctl_o == 8'h00, "R7 read strobe clears unread", int'(err_ctl_o), 0);
    endtask

    task automatic t_inject_held();
        wr_ctl(0, 8'h00);
        wr_ctl(1, 8'h00);
        rd_pulse();
        @(negedge clk);
        conv_code_i = 2'b00; samp_code_i = 2'b00;
        cmp_result_i = 10'h111;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!compare_o) @(negedge clk);
        inject_i = 1'b1;
        @(negedge clk);
        inject_i = 1'b0;
        while (!transfer_o) @(negedge clk);
        cmp_result_i = 10'h222;
        while (transfer_o) @(negedge clk);
        check(sample_o && injected_o, "R8 inject starts right after",
              int'({sample_o, injected_o}), 3);
        check(result_o == 10'h111, "R8 standard result stored", int'(result_o), 'h111);
        check(err_ctl_o == 8'h00, "R8 no error before injected store", int'(err_ctl_o), 0);
        wait_idle();
        check(inj_result_o == 10'h222, "R8 injected result register", int'(inj_result_o), 'h222);
        check(result_o == 10'h111, "R8 standard result untouched", int'(result_o), 'h111);
        check(err_ctl_o == 8'h80, "R8 injected store sets request", int'(err_ctl_o), 'h80);
        check(!injected_o, "R8 injected marker cleared", int'(injected_o), 0);
    endtask

    task automatic t_both_idle();
        @(negedge clk);
        cmp_result_i = 10'h333;
        start_i = 1'b1;
        inject_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        inject_i = 1'b0;
        check(sample_o && injected_o, "R9 inject wins over start",
              int'({sample_o, injected_o}), 3);
        wait_idle();
        repeat (3) @(negedge clk);
        check(!sample_o, "R9 standard start dropped", int'(sample_o), 0);
        check(result_o == 10'h111 && inj_result_o == 10'h333, "R9 only injected register",
              int'(inj_result_o), 'h333);
    endtask

    task automatic t_ctl_regs();
        wr_ctl(0, 8'hA5);
        check(eoc_ctl_o == 8'hA5, "R10 load end-of-conversion register", int'(eoc_ctl_o), 'hA5);
        wr_ctl(1, 8'h3C);
        check(err_ctl_o == 8'h3C, "R10 load error register", int'(err_ctl_o), 'h3C);
        wr_ctl(0, 8'h00);
        check(eoc_ctl_o == 8'h00, "R10 software clear", int'(eoc_ctl_o), 0);
        @(negedge clk);
        conv_code_i = 2'b00; samp_code_i = 2'b00;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!transfer_o) @(negedge clk);
        repeat (27) @(negedge clk);
        icr_wr_i = 2'b01;
        icr_wdata_i = 8'h00;
        @(negedge clk);
        icr_wr_i = 2'b00;
        check(eoc_ctl_o == 8'h80, "R10 hardware set beats write", int'(eoc_ctl_o), 'h80);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_latch_codes();
        t_busy_start();
        t_result_overrun();
        t_inject_held();
        t_both_idle();
        t_ctl_regs();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule